// File: doc/BRIEF.md
# Multi-Slot Compare Event Generator

This block sits beside a free-running 32-bit up-counter and turns it into a one-shot event source without ever stopping or reloading it. Software reads the counter, adds a delay modulo 2^32, and writes the sum into one of several compare slots. When the counter later reaches that value, the block raises a single-cycle interrupt pulse. The same counter can therefore keep serving as a timestamp.

Each slot has a 32-bit compare register and an enable bit. A slot fires only on the cycle the counter moves into equality with its value. A value that already equals the count at the moment it is written or enabled does not fire. Firing clears the slot's enable, so each arming yields at most one event. A sticky per-slot status bit records every event, and software clears it by writing 1. The interrupt line is separate from the counter's own overflow interrupt. Only the low counter word is watched.

Top module: `cmp_evt_gen`

## Requirements
- R1: After reset `irq_o` is 0, `status_o` is 0 and every slot is disabled.
- R2: Slot i's compare register is written at byte address 0x60 + 4*i (0x60..0x7C for eight slots). When an enabled slot's value equals `count_i`, status bit i is set and `irq_o` is high in the cycle after the counter presented that value.
- R3: The enable register at byte address 0x58 holds bit i for slot i, and a write replaces all enables. A slot whose enable bit is 0 never fires.
- R4: Firing clears the slot's enable bit, so the counter equalling the value again fires nothing until software re-enables the slot.
- R5: A slot fires only when `count_i` changes into equality with its value. If the count already equals the value when the compare register or the enable is written, nothing fires while the count holds. A later new arrival at that value does fire.
- R6: `irq_o` is a one-cycle pulse per firing, even if `count_i` holds the matching value for several cycles.
- R7: Slots that fire in the same cycle all set their status bits, and exactly one `irq_o` pulse results.
- R8: The status register at byte address 0x5C is write-1-to-clear, and bits written as 0 are unaffected. If a bit is set and cleared in the same cycle, setting wins.
- R9: A compare value computed as count plus delta modulo 2^32 fires after the counter wraps from 0xFFFFFFFF to 0.
- R10: Writes to any other address, including misaligned ones such as 0x61, change no compare value, enable or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 32 | Current value of the free-running low counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| irq_o | output | 1 | Compare-match interrupt pulse |
| status_o | output | 8 | Sticky per-slot event flags |

## Verification
A stuck or stale equality tracker shows up at the ports as an event that is either missing or doubled. A doubled event appears as a second `irq_o` pulse, or as a pulse on a value that was already present when the slot was written. The bench holds the count on the matching value for several cycles to expose this. An enable bit that fails to clear after firing shows as a second pulse when the bench presents the same count again. A wrong address decode lets a stray write move a slot, which shows as a missed or early event. Each of these is visible in the cycle right after the offending count or write, so the scoreboard compares `irq_o` and `status_o` on every cycle.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned ADDR_W = 8;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic  vld;
    addr_t addr;
    cnt_t  data;
  } wr_t;

  function automatic addr_t slot_addr(addr_t base, int unsigned idx);
    return base + addr_t'(idx * 4);
  endfunction
endpackage

// File: rtl/cmp_evt_regs.sv
module cmp_evt_regs
  import cmp_evt_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter addr_t       CMP_BASE  = 8'h60,
  parameter addr_t       EN_OFS    = 8'h58,
  parameter addr_t       STS_OFS   = 8'h5C
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  wr_t                  wr_i,
  input  logic [NUM_SLOTS-1:0] fire_i,
  output cnt_t                 cmp_o    [NUM_SLOTS],
  output logic [NUM_SLOTS-1:0] cmp_wr_o,
  output logic [NUM_SLOTS-1:0] en_o,
  output logic [NUM_SLOTS-1:0] sts_clr_o
);
  logic                 en_wr, sts_wr;
  logic [NUM_SLOTS-1:0] en_q;

  assign en_wr  = wr_i.vld && (wr_i.addr == EN_OFS);
  assign sts_wr = wr_i.vld && (wr_i.addr == STS_OFS);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    cnt_t cmp_q;
    assign cmp_wr_o[i] = wr_i.vld && (wr_i.addr == slot_addr(CMP_BASE, i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cmp_q <= '0;
      else if (cmp_wr_o[i]) cmp_q <= wr_i.data;
    end
    assign cmp_o[i] = cmp_q;
  end

  // software write wins over one-shot clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_wr) en_q <= wr_i.data[NUM_SLOTS-1:0];
    else            en_q <= en_q & ~fire_i;
  end

  assign en_o      = en_q;
  assign sts_clr_o = sts_wr ? wr_i.data[NUM_SLOTS-1:0] : '0;

  // R3
  fire_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i & ~en_q) == '0);

  // R4
  oneshot_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|fire_i) && !en_wr) |=> ((en_q & $past(fire_i)) == '0));
endmodule

// File: rtl/cmp_evt_slot.sv
module cmp_evt_slot
  import cmp_evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t count_i,
  input  cnt_t cmp_i,
  input  logic wr_i,
  input  cnt_t wr_data_i,
  input  logic en_i,
  output logic fire_o
);
  logic hit_now, hit_q;

  assign hit_now = (count_i == cmp_i);

  // on a compare write, preload equality with the new value so a present match is masked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hit_q <= 1'b0;
    else if (wr_i) hit_q <= (count_i == wr_data_i);
    else           hit_q <= hit_now;
  end

  assign fire_o = en_i && hit_now && !hit_q;

  // R6
  single_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (!fire_o || (count_i != $past(count_i))));

  // R5
  no_present_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (wr_data_i == count_i)) |=> (!fire_o || (count_i != $past(count_i))));
endmodule

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq #(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] fire_i,
  input  logic [NUM_SLOTS-1:0] clr_i,
  output logic                 irq_o,
  output logic [NUM_SLOTS-1:0] sts_o
);
  logic [NUM_SLOTS-1:0] sts_q;
  logic                 irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_i) | fire_i;
      irq_q <= |fire_i;
    end
  end

  assign irq_o = irq_q;
  assign sts_o = sts_q;

  // R8
  irq_has_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts_o != '0));

  // R8
  sticky_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
endmodule

// File: rtl/cmp_evt_gen.sv
module cmp_evt_gen
  import cmp_evt_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter addr_t       CMP_BASE  = 8'h60,
  parameter addr_t       EN_OFS    = 8'h58,
  parameter addr_t       STS_OFS   = 8'h5C
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     count_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  output logic                 irq_o,
  output logic [NUM_SLOTS-1:0] status_o
);
  wr_t                  wr;
  cnt_t                 cmp      [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] cmp_wr, en, sts_clr, fire;

  assign wr = '{vld: wr_en_i, addr: wr_addr_i, data: wr_data_i};

  cmp_evt_regs #(
    .NUM_SLOTS(NUM_SLOTS), .CMP_BASE(CMP_BASE), .EN_OFS(EN_OFS), .STS_OFS(STS_OFS)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .fire_i   (fire),
    .cmp_o    (cmp),
    .cmp_wr_o (cmp_wr),
    .en_o     (en),
    .sts_clr_o(sts_clr)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    cmp_evt_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .count_i  (count_i),
      .cmp_i    (cmp[i]),
      .wr_i     (cmp_wr[i]),
      .wr_data_i(wr_data_i),
      .en_i     (en[i]),
      .fire_o   (fire[i])
    );
  end

  cmp_evt_irq #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .clr_i (sts_clr),
    .irq_o (irq_o),
    .sts_o (status_o)
  );
endmodule

// File: tb/cmp_evt_gen_tb.sv
module cmp_evt_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] count = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        irq;
  logic [7:0]  status;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic       irq;
    logic [7:0] sts;
    string      tag;
  } exp_t;
  exp_t scb[$];

  always #4 clk = ~clk;

  cmp_evt_gen u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .count_i  (count),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .irq_o    (irq),
    .status_o (status)
  );

  // drive one cycle of inputs and queue the outputs expected after the next edge
  task automatic step(input logic [31:0] cnt, input logic we, input logic [7:0] a,
                      input logic [31:0] d, input logic e_irq, input logic [7:0] e_sts,
                      input string tag);
    exp_t e;
    @(negedge clk);
    count   = cnt;
    wr_en   = we;
    wr_addr = a;
    wr_data = d;
    e.irq = e_irq; e.sts = e_sts; e.tag = tag;
    scb.push_back(e);
  endtask

  task automatic tk(input logic [31:0] cnt, input logic e_irq, input logic [7:0] e_sts,
                    input string tag);
    step(cnt, 1'b0, 8'h00, 32'h0, e_irq, e_sts, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (scb.size() > 0) begin
      exp_t e;
      e = scb.pop_front();
      vectors++;
      if (irq !== e.irq || status !== e.sts) begin
        errors++;
        $display("FAIL %s: irq=%0b status=%02h expected irq=%0b status=%02h",
                 e.tag, irq, status, e.irq, e.sts);
      end
    end
  end

  initial begin
    logic [31:0] base, tgt;
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (irq !== 1'b0 || status !== 8'h00) begin
      errors++;
      $display("FAIL R1: irq=%0b status=%02h expected irq=0 status=00", irq, status);
    end
    rst_n = 1'b1;
    tk(32'd0, 1'b0, 8'h00, "R1 idle after reset");

    // R2 basic event on slot 0
    step(32'd90, 1'b1, 8'h60, 32'd100, 1'b0, 8'h00, "R2 cmp write");
    step(32'd91, 1'b1, 8'h58, 32'h01,  1'b0, 8'h00, "R3 enable write");
    tk(32'd99,  1'b0, 8'h00, "R2 before match");
    tk(32'd100, 1'b1, 8'h01, "R2 match");
    tk(32'd101, 1'b0, 8'h01, "R6 pulse ends");
    step(32'd102, 1'b1, 8'h5C, 32'h01, 1'b0, 8'h00, "R8 w1c");
    // R4 one-shot
    tk(32'd100, 1'b0, 8'h00, "R4 no refire");
    tk(32'd101, 1'b0, 8'h00, "R4 idle");
    // R3 disabled slot
    step(32'd150, 1'b1, 8'h64, 32'd200, 1'b0, 8'h00, "R3 cmp1 write");
    tk(32'd200, 1'b0, 8'h00, "R3 disabled slot silent");
    // R6 held count
    step(32'd290, 1'b1, 8'h68, 32'd300, 1'b0, 8'h00, "R6 cmp2 write");
    step(32'd291, 1'b1, 8'h58, 32'h04,  1'b0, 8'h00, "R6 enable");
    tk(32'd300, 1'b1, 8'h04, "R6 match");
    tk(32'd300, 1'b0, 8'h04, "R6 held 1");
    tk(32'd300, 1'b0, 8'h04, "R6 held 2");
    step(32'd301, 1'b1, 8'h5C, 32'h04, 1'b0, 8'h00, "R8 w1c");
    // R5 value already present
    step(32'd400, 1'b1, 8'h6C, 32'd400, 1'b0, 8'h00, "R5 cmp3 equal at write");
    step(32'd400, 1'b1, 8'h58, 32'h08,  1'b0, 8'h00, "R5 enable while equal");
    tk(32'd400, 1'b0, 8'h00, "R5 held equal");
    tk(32'd401, 1'b0, 8'h00, "R5 leave");
    tk(32'd400, 1'b1, 8'h08, "R5 new arrival fires");
    step(32'd402, 1'b1, 8'h5C, 32'h08, 1'b0, 8'h00, "R8 w1c");
    // R7 simultaneous
    step(32'd450, 1'b1, 8'h70, 32'd500, 1'b0, 8'h00, "R7 cmp4");
    step(32'd451, 1'b1, 8'h74, 32'd500, 1'b0, 8'h00, "R7 cmp5");
    step(32'd452, 1'b1, 8'h58, 32'h30,  1'b0, 8'h00, "R7 enable");
    tk(32'd499, 1'b0, 8'h00, "R7 before");
    tk(32'd500, 1'b1, 8'h30, "R7 both set one pulse");
    tk(32'd501, 1'b0, 8'h30, "R7 single pulse");
    step(32'd502, 1'b1, 8'h5C, 32'h30, 1'b0, 8'h00, "R8 w1c both");
    // R8 set beats clear, zero bits untouched
    step(32'd550, 1'b1, 8'h78, 32'd600, 1'b0, 8'h00, "R8 cmp6");
    step(32'd551, 1'b1, 8'h58, 32'h40,  1'b0, 8'h00, "R8 enable");
    step(32'd600, 1'b1, 8'h5C, 32'h40,  1'b1, 8'h40, "R8 set wins");
    step(32'd601, 1'b1, 8'h5C, 32'h00,  1'b0, 8'h40, "R8 zero bits");
    step(32'd602, 1'b1, 8'h5C, 32'h40,  1'b0, 8'h00, "R8 clear");
    // R9 wraparound
    base = 32'hFFFF_FFF0;
    tgt  = base + 32'h20;
    step(base, 1'b1, 8'h7C, tgt, 1'b0, 8'h00, "R9 cmp7");
    step(base + 32'd1, 1'b1, 8'h58, 32'h80, 1'b0, 8'h00, "R9 enable");
    tk(32'hFFFF_FFFF, 1'b0, 8'h00, "R9 top");
    tk(32'h0000_0000, 1'b0, 8'h00, "R9 wrapped");
    tk(tgt, 1'b1, 8'h80, "R9 match after wrap");
    step(tgt + 32'd1, 1'b1, 8'h5C, 32'h80, 1'b0, 8'h00, "R8 w1c");
    // R10 stray addresses
    step(32'd650, 1'b1, 8'h60, 32'd700, 1'b0, 8'h00, "R10 cmp0");
    step(32'd651, 1'b1, 8'h58, 32'h01,  1'b0, 8'h00, "R10 enable");
    step(32'd652, 1'b1, 8'h61, 32'd710, 1'b0, 8'h00, "R10 misaligned");
    step(32'd653, 1'b1, 8'h84, 32'hFF,  1'b0, 8'h00, "R10 unmapped");
    step(32'd654, 1'b1, 8'h5D, 32'hFF,  1'b0, 8'h00, "R10 near status");
    tk(32'd710, 1'b0, 8'h00, "R10 stray value ignored");
    tk(32'd700, 1'b1, 8'h01, "R10 original value kept");
    tk(32'd701, 1'b0, 8'h01, "R10 after");

    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule